// File: doc/BRIEF.md
# I2C Register Master with Host Mailboxes

This block lets a host CPU perform single-byte register accesses on I2C targets through four 16-bit mailbox registers. The host first fills the operand mailbox (register address in the low byte, write data in the high byte). It then writes one command word that carries the direction and the 7-bit target address. The block runs the whole bus transaction on its own. It drives SCL and SDA as open-drain lines (drive-low enables plus a sampled SDA input) at a rate set by a parameterised divider.

Progress and outcome appear in a status word. Bit 12 is busy, bit 13 is a sticky NACK error and bit 14 is a read-complete flag. The byte returned by a read sits in the upper byte of the read mailbox. Register select encoding: 0 = status, 1 = operand mailbox, 2 = command, 3 = read mailbox.

Top module: `i2c_mbox_master`

## Requirements
- R1: After reset, and whenever no transaction is running, the status word reads 0 apart from sticky flags, and both drive-low enables are deasserted.
- R2: A command word 0xC4 in bits 15:8, with the target address in bits 7:1 and bit 0 zero, performs START, address+W, register byte (operand bits 7:0), data byte (operand bits 15:8), STOP. The target register then holds the data byte.
- R3: Status bit 12 is set from the cycle after an accepted command until the final STOP has completed. A write occupies 29 bus operations and a read 39, each of four quarter-periods.
- R4: A command word 0xC0 in bits 15:8 performs START, address+W, register byte, repeated START, address+R, one data byte answered with NACK, STOP. The received byte appears in bits 15:8 of the read mailbox (select 3), and status bit 14 becomes set.
- R5: Writing a 1 to status bit 14 clears it. Writing 0 there leaves it unchanged.
- R6: If the address byte is not acknowledged, the block issues STOP at once and clears busy, after 11 bus operations in total. It also sets status bit 13, which stays set across later transactions until the host writes a 1 to bit 13.
- R7: If a register or data byte is not acknowledged, the transfer ends with STOP and status bit 13 becomes set. The target register is not changed.
- R8: A command written while busy is set is ignored, and the running transaction completes with its original operands.
- R9: SDA changes only while SCL is low, except at START and STOP. A write shows exactly one START and one STOP; a read shows two STARTs and one STOP.
- R10: The SCL period during a transfer is 4 × QTR_DIV system clock cycles.
- R11: A command word is accepted only if bits 15:11 are 11000, bits 9:8 are 00 and bit 0 is 0. Any other command word starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select (0 status, 1 operand, 2 command, 3 read mailbox) |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register (combinational) |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
Busy is due one cycle after the command write. The bench reads the status at the next falling edge and expects bit 12 there.

Completion is due after the operation count times 4 × QTR_DIV cycles, plus at most one divider period of launch latency. The bench therefore counts cycles until busy falls and accepts only a window a few cycles wide around 29, 39 or 11 operations. Stored bytes, the read mailbox and the flags are compared only after busy has fallen, and the SCL period is measured from the last two rising edges seen by the bench's target model.

// File: rtl/i2c_mbox_pkg.sv
package i2c_mbox_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} bit_op_e;
  typedef enum logic [1:0] {K_START, K_TXB, K_RXB, K_STOP} step_e;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_OPND   = 2'd1;
  localparam logic [1:0] SEL_CMD    = 2'd2;
  localparam logic [1:0] SEL_RDBOX  = 2'd3;

  localparam int BUSY_BIT  = 12;
  localparam int NACK_BIT  = 13;
  localparam int RDONE_BIT = 14;
  localparam int DIR_BIT   = 10;
endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int QTR_DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (QTR_DIV > 1) begin : g_gap
      // R10
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_mbox_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    req_i,
  input  bit_op_e op_i,
  input  logic    tx_i,
  output logic    ready_o,
  output logic    done_o,
  output logic    rx_o,
  output logic    scl_o,
  output logic    sda_o,
  input  logic    sda_i
);
  logic       running_q, done_q, rx_q, tx_q, scl_q, sda_q;
  logic [1:0] phase_q;
  bit_op_e    op_q;

  // Every operation is four quarter-periods; line levels change on ticks only.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      rx_q      <= 1'b1;
      tx_q      <= 1'b1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      phase_q   <= '0;
      op_q      <= OP_STOP;
    end else begin
      done_q <= 1'b0;
      if (!running_q && req_i) begin
        running_q <= 1'b1;
        phase_q   <= '0;
        op_q      <= op_i;
        tx_q      <= tx_i;
      end else if (running_q && tick_i) begin
        phase_q <= phase_q + 1'b1;
        unique case (op_q)
          OP_START: unique case (phase_q)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b0;
            2'd3: scl_q <= 1'b0;
          endcase
          OP_STOP: unique case (phase_q)
            2'd0: sda_q <= 1'b0;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b1;
            2'd3: ;
          endcase
          default: unique case (phase_q)
            2'd0: sda_q <= tx_q;
            2'd1: scl_q <= 1'b1;
            2'd2: rx_q  <= sda_i;
            2'd3: scl_q <= 1'b0;
          endcase
        endcase
        if (phase_q == 2'd3) begin
          running_q <= 1'b0;
          done_q    <= 1'b1;
        end
      end
    end
  end

  assign ready_o = !running_q;
  assign done_o  = done_q;
  assign rx_o    = rx_q;
  assign scl_o   = scl_q;
  assign sda_o   = sda_q;

  // R9
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && op_q == OP_BIT && scl_q && $past(scl_q)) |-> $stable(sda_q));
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       is_rd_i,
  input  logic [6:0] dev_i,
  input  logic [7:0] reg_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       nack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_byte_o,
  output logic       eng_req_o,
  output bit_op_e    eng_op_o,
  output logic       eng_tx_o,
  input  logic       eng_ready_i,
  input  logic       eng_done_i,
  input  logic       eng_rx_i
);
  logic       busy_q, wait_q, is_rd_q, nack_q, rdv_q;
  logic [2:0] idx_q;
  logic [3:0] bit_q;
  logic [6:0] dev_q;
  logic [7:0] reg_q, dat_q, rxsh_q, rd_byte_q;

  function automatic step_e kind_of(input logic rd, input logic [2:0] idx);
    if (!rd) begin
      unique case (idx)
        3'd0:             return K_START;
        3'd1, 3'd2, 3'd3: return K_TXB;
        default:          return K_STOP;
      endcase
    end else begin
      unique case (idx)
        3'd0, 3'd3:       return K_START;
        3'd1, 3'd2, 3'd4: return K_TXB;
        3'd5:             return K_RXB;
        default:          return K_STOP;
      endcase
    end
  endfunction

  step_e      cur_kind;
  logic [7:0] txb;
  logic [2:0] bsel, stop_idx;

  always_comb begin
    cur_kind = kind_of(is_rd_q, idx_q);
    stop_idx = is_rd_q ? 3'd6 : 3'd4;
    bsel     = 3'd7 - bit_q[2:0];
    unique case (idx_q)
      3'd1:    txb = {dev_q, 1'b0};
      3'd2:    txb = reg_q;
      3'd3:    txb = dat_q;
      3'd4:    txb = {dev_q, 1'b1};
      default: txb = 8'hFF;
    endcase
    unique case (cur_kind)
      K_START: eng_op_o = OP_START;
      K_STOP:  eng_op_o = OP_STOP;
      default: eng_op_o = OP_BIT;
    endcase
    eng_tx_o = (cur_kind == K_TXB && bit_q != 4'd8) ? txb[bsel] : 1'b1;
  end

  assign eng_req_o = busy_q && !wait_q && eng_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; wait_q <= 1'b0; is_rd_q <= 1'b0;
      nack_q <= 1'b0; rdv_q  <= 1'b0;
      idx_q  <= '0;   bit_q  <= '0;   dev_q   <= '0;
      reg_q  <= '0;   dat_q  <= '0;   rxsh_q  <= '0; rd_byte_q <= '0;
    end else begin
      nack_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          wait_q  <= 1'b0;
          idx_q   <= '0;
          bit_q   <= '0;
          is_rd_q <= is_rd_i;
          dev_q   <= dev_i;
          reg_q   <= reg_i;
          dat_q   <= data_i;
        end
      end else if (!wait_q) begin
        if (eng_req_o) wait_q <= 1'b1;
      end else if (eng_done_i) begin
        wait_q <= 1'b0;
        unique case (cur_kind)
          K_START: idx_q <= idx_q + 1'b1;
          K_TXB: begin
            if (bit_q != 4'd8) bit_q <= bit_q + 1'b1;
            else begin
              bit_q <= '0;
              if (eng_rx_i) begin
                nack_q <= 1'b1;
                idx_q  <= stop_idx;
              end else idx_q <= idx_q + 1'b1;
            end
          end
          K_RXB: begin
            if (bit_q != 4'd8) begin
              rxsh_q <= {rxsh_q[6:0], eng_rx_i};
              bit_q  <= bit_q + 1'b1;
            end else begin
              bit_q     <= '0;
              idx_q     <= idx_q + 1'b1;
              rd_byte_q <= rxsh_q;
              rdv_q     <= 1'b1;
            end
          end
          K_STOP: busy_q <= 1'b0;
        endcase
      end
    end
  end

  assign busy_o     = busy_q;
  assign nack_o     = nack_q;
  assign rd_valid_o = rdv_q;
  assign rd_byte_o  = rd_byte_q;

  // R8
  ignore_busy_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q) |=> ($stable(dev_q) && $stable(is_rd_q) && $stable(reg_q) && $stable(dat_q)));
endmodule

// File: rtl/i2c_mbox_master.sv
module i2c_mbox_master
  import i2c_mbox_pkg::*;
#(
  parameter int QTR_DIV = 125
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  reg_sel_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  logic        tick, eng_req, eng_tx, eng_ready, eng_done, eng_rx, scl_lvl, sda_lvl;
  bit_op_e     eng_op;
  logic        seq_busy, seq_nack, seq_rdv;
  logic [7:0]  rd_byte;
  logic [15:0] opnd_q;
  logic        stat_nack_q, stat_rdone_q;
  logic        cmd_ok, cmd_go;

  assign cmd_ok = (reg_wdata_i[15:11] == 5'b11000) && (reg_wdata_i[9:8] == 2'b00)
                  && !reg_wdata_i[0];
  assign cmd_go = reg_we_i && (reg_sel_i == SEL_CMD) && cmd_ok;

  i2c_tick_gen #(.QTR_DIV(QTR_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  i2c_byte_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(cmd_go), .is_rd_i(!reg_wdata_i[DIR_BIT]), .dev_i(reg_wdata_i[7:1]),
    .reg_i(opnd_q[7:0]), .data_i(opnd_q[15:8]),
    .busy_o(seq_busy), .nack_o(seq_nack), .rd_valid_o(seq_rdv), .rd_byte_o(rd_byte),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_tx_o(eng_tx),
    .eng_ready_i(eng_ready), .eng_done_i(eng_done), .eng_rx_i(eng_rx));

  i2c_bit_engine u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .req_i(eng_req), .op_i(eng_op), .tx_i(eng_tx),
    .ready_o(eng_ready), .done_o(eng_done), .rx_o(eng_rx),
    .scl_o(scl_lvl), .sda_o(sda_lvl), .sda_i(sda_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_q       <= '0;
      stat_nack_q  <= 1'b0;
      stat_rdone_q <= 1'b0;
    end else begin
      if (reg_we_i && reg_sel_i == SEL_OPND) opnd_q <= reg_wdata_i;
      // set wins over a same-cycle clear
      if (seq_nack)
        stat_nack_q <= 1'b1;
      else if (reg_we_i && reg_sel_i == SEL_STATUS && reg_wdata_i[NACK_BIT])
        stat_nack_q <= 1'b0;
      if (seq_rdv)
        stat_rdone_q <= 1'b1;
      else if (reg_we_i && reg_sel_i == SEL_STATUS && reg_wdata_i[RDONE_BIT])
        stat_rdone_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_STATUS: begin
        reg_rdata_o[BUSY_BIT]  = seq_busy;
        reg_rdata_o[NACK_BIT]  = stat_nack_q;
        reg_rdata_o[RDONE_BIT] = stat_rdone_q;
      end
      SEL_OPND:  reg_rdata_o = opnd_q;
      SEL_CMD:   reg_rdata_o = '0;
      SEL_RDBOX: reg_rdata_o = {rd_byte, 8'h00};
    endcase
  end

  assign scl_oe_o = !scl_lvl;
  assign sda_oe_o = !sda_lvl;

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_busy |-> (!scl_oe_o && !sda_oe_o));
  // R4
  rdone_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_rdone_q) |-> $past(seq_rdv));
  // R6
  nack_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_nack |=> stat_nack_q);
endmodule

// File: tb/sim_i2c_mbox_master.sv
`timescale 1ns/1ps
module sim_i2c_mbox_master;
  localparam int Q   = 4;
  localparam int OPC = 4 * Q;
  localparam logic [6:0] SLV = 7'h3A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        scl_oe, sda_oe;
  logic        s_drv = 1'b0;
  logic        scl_l, sda_l;

  assign scl_l = !scl_oe;
  assign sda_l = !(sda_oe || s_drv);

  always #4 clk = ~clk;

  i2c_mbox_master #(.QTR_DIV(Q)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_l));

  int n_chk = 0;
  int n_fail = 0;

  // target model
  logic [7:0] smem [16];
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         bitc = 0, byten = 0, n_start = 0, n_stop = 0, cyc = 0, last_rise = 0, rise_gap = 0;
  logic       tx = 1'b0, matched = 1'b0, rw = 1'b0;
  logic [7:0] sh = '0, ptr = '0, txd = '0;

  always @(negedge clk) begin
    cyc++;
    if (p_scl && scl_l && p_sda && !sda_l) begin
      n_start++; bitc = 0; byten = 0; tx = 1'b0; s_drv = 1'b0;
    end else if (p_scl && scl_l && !p_sda && sda_l) begin
      n_stop++; bitc = 0; tx = 1'b0; s_drv = 1'b0;
    end else if (!p_scl && scl_l) begin
      rise_gap = cyc - last_rise; last_rise = cyc;
      if (bitc < 8 && !tx) sh = {sh[6:0], sda_l};
      bitc++;
    end else if (p_scl && !scl_l) begin
      if (bitc == 8) begin
        if (tx) s_drv = 1'b0;
        else if (byten == 0) begin
          matched = (sh[7:1] == SLV); rw = sh[0]; s_drv = matched;
        end else if (matched && !rw) begin
          if (byten == 1) begin ptr = sh; s_drv = 1'b1; end
          else if (sh == 8'hEE) s_drv = 1'b0;
          else begin smem[ptr[3:0]] = sh; s_drv = 1'b1; end
        end else s_drv = 1'b0;
      end else if (bitc == 9) begin
        bitc = 0;
        if (byten == 0 && matched && rw && !tx) begin
          tx = 1'b1; txd = smem[ptr[3:0]]; s_drv = !txd[7];
        end else begin
          tx = 1'b0; s_drv = 1'b0;
        end
        byten++;
      end else if (tx && bitc >= 1 && bitc <= 7) s_drv = !txd[7-bitc];
    end
    p_scl = scl_l; p_sda = sda_l;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); sel = s; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; sel = 2'd0;
  endtask

  task automatic hread(input logic [1:0] s, output logic [15:0] d);
    sel = s; #1; d = rdata; sel = 2'd0;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] st;
    n = 0;
    hread(2'd0, st);
    while (st[12] && n < 3000) begin
      @(negedge clk); n++; hread(2'd0, st);
    end
  endtask

  task automatic in_window(input string tag, input int n, input int ops);
    chk(tag, (n >= ops*OPC - 6 && n <= ops*OPC + 4), 1);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    hread(2'd0, d);  chk("R1 status after reset", d, 16'h0);
    hread(2'd3, d);  chk("R1 read mailbox after reset", d, 16'h0);
    chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_write;
    logic [15:0] d; int n;
    n_start = 0; n_stop = 0;
    hwrite(2'd1, 16'hA503);
    hwrite(2'd2, 16'hC400 | {8'h0, SLV, 1'b0});
    hread(2'd0, d); chk("R3 busy after write cmd", d[12], 1);
    wait_idle(n);
    in_window("R3 write duration", n, 29);
    chk("R2 target reg 3 written", smem[3], 8'hA5);
    chk("R9 write starts", n_start, 1);
    chk("R9 write stops", n_stop, 1);
    chk("R10 scl period", rise_gap, OPC);
    hread(2'd0, d); chk("R6 no nack on good write", d[13], 0);
    chk("R1 lines released after write", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_read(input logic [7:0] r, input logic [7:0] exp);
    logic [15:0] d; int n;
    n_start = 0; n_stop = 0;
    hwrite(2'd1, {8'h77, r});
    hwrite(2'd2, 16'hC000 | {8'h0, SLV, 1'b0});
    hread(2'd0, d); chk("R3 busy after read cmd", d[12], 1);
    wait_idle(n);
    in_window("R4 read duration", n, 39);
    hread(2'd3, d); chk("R4 read byte", d, {exp, 8'h00});
    hread(2'd0, d); chk("R4 read-complete flag", d[14], 1);
    chk("R9 read starts", n_start, 2);
    chk("R9 read stops", n_stop, 1);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    hwrite(2'd0, 16'h0000);
    hread(2'd0, d); chk("R5 write 0 keeps flag", d[14], 1);
    hwrite(2'd0, 16'h4000);
    hread(2'd0, d); chk("R5 write 1 clears flag", d[14], 0);
  endtask

  task automatic t_busy_cmd;
    logic [15:0] d; int n;
    n_start = 0;
    hwrite(2'd1, 16'h1106);
    hwrite(2'd2, 16'hC400 | {8'h0, SLV, 1'b0});
    hwrite(2'd1, 16'h2207);
    hwrite(2'd2, 16'hC400 | {8'h0, SLV, 1'b0});
    wait_idle(n);
    in_window("R8 single transaction duration", n + 2, 29);
    chk("R8 first write done", smem[6], 8'h11);
    chk("R8 second command ignored", smem[7], 8'h57);
    chk("R8 one start only", n_start, 1);
    hread(2'd0, d); chk("R8 not busy after", d[12], 0);
  endtask

  task automatic t_addr_nack;
    logic [15:0] d; int n;
    hwrite(2'd1, 16'h9909);
    hwrite(2'd2, 16'hC424);
    wait_idle(n);
    in_window("R6 early stop", n, 11);
    hread(2'd0, d); chk("R6 nack flag set", d[13], 1);
    chk("R6 memory untouched", smem[9], 8'h59);
    hwrite(2'd1, 16'h330A);
    hwrite(2'd2, 16'hC400 | {8'h0, SLV, 1'b0});
    wait_idle(n);
    hread(2'd0, d); chk("R6 nack sticky", d[13], 1);
    chk("R6 later write ok", smem[10], 8'h33);
    hwrite(2'd0, 16'h2000);
    hread(2'd0, d); chk("R6 nack cleared", d[13], 0);
  endtask

  task automatic t_data_nack;
    logic [15:0] d; int n;
    hwrite(2'd1, 16'hEE08);
    hwrite(2'd2, 16'hC400 | {8'h0, SLV, 1'b0});
    wait_idle(n);
    in_window("R7 data nack duration", n, 29);
    hread(2'd0, d); chk("R7 nack flag set", d[13], 1);
    chk("R7 reg unchanged", smem[8], 8'h58);
    hwrite(2'd0, 16'h2000);
  endtask

  task automatic t_bad_cmd;
    logic [15:0] d;
    n_start = 0;
    hwrite(2'd2, 16'hC475);
    hread(2'd0, d); chk("R11 bit0 set ignored", d[12], 0);
    hwrite(2'd2, 16'h8474);
    hread(2'd0, d); chk("R11 bad marker ignored", d[12], 0);
    hwrite(2'd2, 16'hC574);
    hread(2'd0, d); chk("R11 bit8 set ignored", d[12], 0);
    repeat (40) @(negedge clk);
    chk("R11 no bus activity", n_start, 0);
  endtask

  initial begin
    #1200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) smem[i] = 8'h50 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read(8'h03, 8'hA5);
    t_w1c();
    t_read(8'h05, 8'h55);
    hwrite(2'd0, 16'h4000);
    t_busy_cmd();
    t_addr_nack();
    t_data_nack();
    t_bad_cmd();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule